// File: doc/BRIEF.md
# Write-Only Serial Control Register Target

This block is a two-wire serial bus target that only accepts write transactions. It fills a small bank of five 8-bit control registers. These registers drive an analog signal-routing fabric. Three of them pick a source for each pair of outputs, one nibble per output. One chooses the DC restore mode per input. One chooses the per-output gain. A fast system clock oversamples the bus lines. Bus events are found from the synchronized samples, and the target answers by pulling the data line low through an open-drain output.

A transaction has a fixed order:

- START
- a device byte, which is acknowledged
- a pointer byte, which is acknowledged
- one or more data bytes, each acknowledged
- STOP

Two select pins shift the device address, so four targets can share one bus. Nothing can be read back.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, all five registers read 0x00 and the SDA pull-down output is deasserted.
- R2: Bits arrive MSB first. The whole first byte after a START, including its last (R/W) bit, must equal {sel[1:0], 6'b000110}, which gives 0x06, 0x46, 0x86 or 0xC6 for sel = 0..3. A matching byte is acknowledged. Any other byte is not.
- R3: A byte that matches except that its last bit is 1 (a read request, e.g. 0x07 for sel = 0) is not acknowledged.
- R4: After an unacknowledged first byte, the target acknowledges nothing further and changes no register until the next START.
- R5: The pull-down is raised only while SCL is low. It is held through the whole high period of the ninth clock and released after that clock's falling edge.
- R6: Pointer values map as follows, and a data byte replaces the whole selected register:
  - 0x00 drives route12 (bits 3:0 for output one, bits 7:4 for output two).
  - 0x01 drives route34.
  - 0x02 drives route56.
  - 0x03 drives clamp.
  - 0x04 drives gain.
- R7: A data byte sent to a pointer above 0x04 is acknowledged and leaves every register unchanged.
- R8: Each further data byte in the same transaction goes to the previous pointer plus one.
- R9: A repeated START, sent without a STOP, restarts address matching. An earlier mismatch does not block a following correct device byte.
- R10: A STOP releases SDA. Register contents change only as a result of a complete, acknowledged data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pd_o | output | 1 | 1 pulls the data line low (open drain) |
| sel_i | input | 2 | Address select, placed in device byte bits 7:6 |
| route12_o | output | 8 | Source selection for outputs one and two |
| route34_o | output | 8 | Source selection for outputs three and four |
| route56_o | output | 8 | Source selection for outputs five and six |
| clamp_o | output | 8 | Per-input clamp/bias selection |
| gain_o | output | 8 | Per-output gain selection |

## Verification
The hardest state to reach is a transaction that carries on after the target has refused the device byte. In that state the bus still toggles through whole bytes, but the target must neither acknowledge nor write. The stimulus reaches it by driving complete pointer and data bytes behind mismatched and read-request device bytes. It also sends a repeated START that follows a refused byte with a correct one. A third case runs multi-byte bursts that walk the pointer past the last defined register.

// File: rtl/i2cw_pkg.sv
`timescale 1ns/1ps
// Package i2cw_pkg: shared types for the write-only serial register target.
package i2cw_pkg;
    // Transaction phase of the target.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
`timescale 1ns/1ps
// i2cw_sync: two-flop synchronizer for asynchronous bus lines.
// Assumes idle lines are high, so reset loads ones.
module i2cw_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two register stages toward the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q_o  <= '1;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/i2cw_events.sv
`timescale 1ns/1ps
// i2cw_events: finds START, STOP and SCL edges from synchronized lines.
// Assumes the inputs are already synchronous to clk.
module i2cw_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic evt_start,
    output logic evt_stop,
    output logic evt_rise,
    output logic evt_fall
);
    logic scl_q, sda_q;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // An SDA edge while SCL stays high is a condition, not data.
    always_comb begin
        evt_start = scl_s && scl_q && sda_q && !sda_s;
        evt_stop  = scl_s && scl_q && !sda_q && sda_s;
        evt_rise  = scl_s && !scl_q;
        evt_fall  = !scl_s && scl_q;
    end
endmodule

// File: rtl/i2cw_ctrl.sv
`timescale 1ns/1ps
// i2cw_ctrl: byte engine of the target. It shifts bits on SCL rises,
// decides on each byte after its eighth falling edge, drives the
// acknowledge and issues register writes.
// Assumes single-cycle bus event strobes from i2cw_events.
module i2cw_ctrl
    import i2cw_pkg::*;
#(
    parameter int          DW   = 8,
    parameter int          NREG = 5,
    parameter logic [5:0]  TAIL = 6'b000110,
    localparam int         IW   = $clog2(NREG),
    localparam int         CW   = $clog2(DW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          evt_start,
    input  logic          evt_stop,
    input  logic          evt_rise,
    input  logic          evt_fall,
    input  logic [1:0]    sel,
    output logic          sda_pd,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    localparam logic [CW-1:0] BYTE_DONE = CW'(DW);
    localparam logic [CW-1:0] ACK_SLOT  = CW'(DW + 1);

    phase_t        phase;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] ptr;
    logic          active;

    always_comb active = (phase == PH_DEV) || (phase == PH_PTR) || (phase == PH_DATA);

    // Transaction sequencing, bit shifting, acknowledge and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_pd  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt_start) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_pd  <= 1'b0;
            end else if (evt_stop) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_pd  <= 1'b0;
            end else if (active) begin
                if (evt_rise && bit_cnt < BYTE_DONE) begin
                    shreg   <= {shreg[DW-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (evt_fall && bit_cnt == BYTE_DONE) begin
                    bit_cnt <= ACK_SLOT;
                    case (phase)
                        PH_DEV: begin
                            if (shreg == {sel, TAIL}) begin
                                sda_pd <= 1'b1;
                                phase  <= PH_PTR;
                            end else begin
                                phase  <= PH_SKIP;
                            end
                        end
                        PH_PTR: begin
                            ptr    <= shreg;
                            sda_pd <= 1'b1;
                            phase  <= PH_DATA;
                        end
                        default: begin
                            sda_pd  <= 1'b1;
                            ptr     <= ptr + 1'b1;
                            wr_en   <= (ptr < DW'(NREG));
                            wr_idx  <= ptr[IW-1:0];
                            wr_data <= shreg;
                        end
                    endcase
                end else if (evt_fall && bit_cnt == ACK_SLOT) begin
                    sda_pd  <= 1'b0;
                    bit_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/i2cw_regfile.sv
`timescale 1ns/1ps
// i2cw_regfile: bank of control registers written one at a time.
// Assumes wr_idx is below NREG whenever wr_en is high.
module i2cw_regfile #(
    parameter int  DW   = 8,
    parameter int  NREG = 5,
    localparam int IW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic [NREG-1:0][DW-1:0]   regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One register, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[g] <= '0;
            else if (wr_en && wr_idx == IW'(g))
                regs_o[g] <= wr_data;
        end
    end
endmodule

// File: rtl/i2c_ctl_regs.sv
`timescale 1ns/1ps
// i2c_ctl_regs: write-only two-wire bus target holding five control
// registers (three routing, clamp, gain).
// Assumes the system clock is much faster than SCL (at least ~8x).
module i2c_ctl_regs #(
    parameter int         DW   = 8,
    parameter int         NREG = 5,
    parameter logic [5:0] TAIL = 6'b000110,
    localparam int        IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pd_o,
    input  logic [1:0]    sel_i,
    output logic [DW-1:0] route12_o,
    output logic [DW-1:0] route34_o,
    output logic [DW-1:0] route56_o,
    output logic [DW-1:0] clamp_o,
    output logic [DW-1:0] gain_o
);
    logic [1:0]                 lines_s;
    logic                       scl_s, sda_s;
    logic                       evt_start, evt_stop, evt_rise, evt_fall;
    logic                       wr_en;
    logic [IW-1:0]              wr_idx;
    logic [DW-1:0]              wr_data;
    logic [NREG-1:0][DW-1:0]    regs;

    i2cw_sync #(.W(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    always_comb begin
        scl_s = lines_s[1];
        sda_s = lines_s[0];
    end

    i2cw_events evt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .evt_rise  (evt_rise),
        .evt_fall  (evt_fall)
    );

    i2cw_ctrl #(.DW(DW), .NREG(NREG), .TAIL(TAIL)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .evt_rise  (evt_rise),
        .evt_fall  (evt_fall),
        .sel       (sel_i),
        .sda_pd    (sda_pd_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    i2cw_regfile #(.DW(DW), .NREG(NREG)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    // Fixed register order: three routing registers, then clamp, then gain.
    always_comb begin
        route12_o = regs[0];
        route34_o = regs[1];
        route56_o = regs[2];
        clamp_o   = regs[3];
        gain_o    = regs[4];
    end
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
`timescale 1ns/1ps
// i2c_ctl_regs_chk: temporal checks on the target, attached by bind.
module i2c_ctl_regs_chk #(
    parameter int W = 40
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         sda_pd,
    input logic         evt_start,
    input logic         evt_stop,
    input logic         evt_fall,
    input logic [W-1:0] regs
);
    // R10: a STOP always leaves the data line released.
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stop |=> !sda_pd);

    // R5: the acknowledge pull-down begins only while SCL is low.
    p_ack_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> !scl_s);

    // R5: the pull-down ends only on an SCL fall or a bus condition.
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pd) |-> $past(evt_fall || evt_stop || evt_start));

    // R10: register contents move only two cycles after an SCL fall.
    p_reg_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(evt_fall, 2));

    // R1: nothing is pulled down while reset holds the outputs.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sda_pd && regs == '0));
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(.W(40)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_pd    (sda_pd_o),
    .evt_start (evt_start),
    .evt_stop  (evt_stop),
    .evt_fall  (evt_fall),
    .regs      (regs)
);

// File: tb/i2c_ctl_regs_tb_top.sv
`timescale 1ns/1ps
// Bench for i2c_ctl_regs: a vector table of single writes, then directed cases.
module i2c_ctl_regs_tb_top;
    localparam int Q   = 10;   // clocks per quarter bit
    localparam int NV  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       sda_pd;
    logic [7:0] route12, route34, route56, clamp, gain;
    logic       sda_bus;
    int         nchk = 0;
    int         nerr = 0;
    bit         done = 1'b0;
    logic [7:0] model [5];

    always #4 clk = ~clk;   // 125 MHz

    assign sda_bus = m_sda & ~sda_pd;

    i2c_ctl_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_pd_o  (sda_pd),
        .sel_i     (sel),
        .route12_o (route12),
        .route34_o (route34),
        .route56_o (route56),
        .clamp_o   (clamp),
        .gain_o    (gain)
    );

    // sel, device byte, pointer, data
    localparam logic [25:0] VEC [NV] = '{
        {2'b00, 8'h06, 8'h00, 8'hA5},
        {2'b01, 8'h46, 8'h01, 8'h3C},
        {2'b10, 8'h86, 8'h02, 8'h7E},
        {2'b11, 8'hC6, 8'h03, 8'h81},
        {2'b00, 8'h06, 8'h04, 8'h3F},
        {2'b00, 8'h46, 8'h00, 8'hFF},
        {2'b00, 8'h07, 8'h01, 8'h00},
        {2'b00, 8'h06, 8'h05, 8'h55},
        {2'b10, 8'h06, 8'h02, 8'h11},
        {2'b00, 8'h06, 8'hFF, 8'h22}
    };

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    // Sends one byte MSB first; ack is sampled mid-way through the ninth high.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ack = sda_pd;
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic check_regs(input string tag);
        check(route12, model[0], tag);
        check(route34, model[1], tag);
        check(route56, model[2], tag);
        check(clamp,   model[3], tag);
        check(gain,    model[4], tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic match;
        for (int k = 0; k < 5; k++) model[k] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R1: reset state
        check_regs("R1 reset regs");
        check({7'd0, sda_pd}, 8'h00, "R1 reset sda");

        // Table walk: R2/R3/R4/R6/R7
        for (int v = 0; v < NV; v++) begin
            sel = VEC[v][25:24];
            match = (VEC[v][23:16] == {sel, 6'b000110});
            bus_start();
            send_byte(VEC[v][23:16], ack);
            check({7'd0, ack}, {7'd0, match}, "R2 R3 device byte ack");
            send_byte(VEC[v][15:8], ack);
            check({7'd0, ack}, {7'd0, match}, "R4 pointer ack");
            send_byte(VEC[v][7:0], ack);
            check({7'd0, ack}, {7'd0, match}, "R4 R7 data ack");
            bus_stop();
            check({7'd0, sda_pd}, 8'h00, "R10 released after stop");
            if (match && VEC[v][15:8] < 8'd5) model[VEC[v][15:8]] = VEC[v][7:0];
            check_regs("R6 R7 R4 register map");
        end

        // R8: burst from pointer 3 runs past the end of the map
        sel = 2'b00;
        bus_start();
        send_byte(8'h06, ack);
        send_byte(8'h03, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        check({7'd0, ack}, 8'h01, "R8 R7 ack past map end");
        bus_stop();
        model[3] = 8'h11; model[4] = 8'h22;
        check_regs("R8 burst from 3");

        // R8: burst from pointer 0
        bus_start();
        send_byte(8'h06, ack);
        send_byte(8'h00, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        send_byte(8'h56, ack);
        bus_stop();
        model[0] = 8'h12; model[1] = 8'h34; model[2] = 8'h56;
        check_regs("R8 burst from 0");

        // R9: refused byte, repeated START, then a correct write
        bus_start();
        send_byte(8'hC6, ack);
        check({7'd0, ack}, 8'h00, "R9 refused before restart");
        bus_start();
        send_byte(8'h06, ack);
        check({7'd0, ack}, 8'h01, "R9 accepted after restart");
        send_byte(8'h01, ack);
        send_byte(8'h99, ack);
        bus_stop();
        model[1] = 8'h99;
        check_regs("R9 repeated start write");

        // R5: pull-down timing around the ninth clock
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'(8'h06 >> i); wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        check({7'd0, sda_pd}, 8'h01, "R5 asserted in low phase");
        m_scl = 1'b1; wq(1);
        check({7'd0, sda_pd}, 8'h01, "R5 held at ninth rise");
        wq(2*Q - 1);
        check({7'd0, sda_pd}, 8'h01, "R5 held late in ninth high");
        m_scl = 1'b0; wq(Q);
        check({7'd0, sda_pd}, 8'h00, "R5 released after ninth fall");
        bus_stop();

        // R1: reset clears written registers
        rst_n = 1'b0; wq(3);
        rst_n = 1'b1; wq(2);
        for (int k = 0; k < 5; k++) model[k] = 8'h00;
        check_regs("R1 reset after writes");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule